// File: doc/BRIEF.md
# Watchdog Counter with Sleep and Wake Status

This block times how long software goes without servicing the watchdog. A free-running tick advances a counter. The tick can pass straight to the counter, or it can first go through a divider that the counter may share with a general-purpose timer. The rate and the assignment of that divider come from the option settings of the core. Two instruction strobes act on the block: the watchdog-clear strobe and the enter-sleep strobe. Both restart the count, and they differ only in the status bits they leave behind.

When the counter runs past its highest value, the block raises a one-cycle timeout pulse and drops the time-out status bit. The block qualifies that pulse as one of two requests. If the core is running, it is a reset request. If the core is sleeping, it is a wake request. The power-down and time-out bits let startup code tell these cases apart from a power-on start.

Top module: `wdog_sleep_top`

## Requirements
- R1: While and after power-on reset (`rstN` low), `toFlag` = 1, `pdFlag` = 1 and `asleep` = 0, and none of `timeoutPulse`, `resetReq` or `wakeReq` is asserted.
- R2: The counter is CNT_W bits wide (default 8). A timeout occurs on the 2^CNT_W-th counter step after a restart. In the cycle after that step, `timeoutPulse` is high for exactly one cycle, and `toFlag` reads 0 from then on until the next clear, sleep or power-on reset.
- R3: A clear-watchdog strobe while awake sets `toFlag` = 1 and `pdFlag` = 1 and returns the counter to zero. A tick in the same cycle as the strobe is discarded.
- R4: An enter-sleep strobe while awake sets `toFlag` = 1, `pdFlag` = 0 and `asleep` = 1, and returns the counter to zero.
- R5: A timeout while awake pulses `resetReq` for one cycle and leaves `wakeReq` low.
- R6: A timeout while asleep pulses `wakeReq` for one cycle, leaves `resetReq` low, clears `asleep` and keeps `pdFlag` at 0.
- R7: While `asleep` = 1, clear-watchdog and enter-sleep strobes have no effect. The count keeps running and the status bits do not change.
- R8: With `prescToWdog` = 1, the counter takes one step for every 2^`prescRate` ticks. With `prescToWdog` = 0, it takes one step on every tick.
- R9: With `prescToWdog` = 0, the divider count is held, and a clear-watchdog strobe leaves it untouched. It resumes from that count once it is assigned back to the watchdog.
- R10: With `prescToWdog` = 1, a clear-watchdog or enter-sleep strobe also returns the divider count to zero.
- R11: A power-on reset during a run returns both the counter and the divider count to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Power-on reset, active low, asynchronous |
| wdogTick | input | 1 | Watchdog tick strobe, one per clock when high |
| prescToWdog | input | 1 | 1 = divider serves the watchdog, 0 = divider belongs to the timer |
| prescRate | input | RATE_W | Divider rate exponent (divide by 2^value) |
| clrWdogCmd | input | 1 | Clear-watchdog instruction strobe |
| sleepCmd | input | 1 | Enter-sleep instruction strobe |
| timeoutPulse | output | 1 | One-cycle pulse on counter overflow |
| resetReq | output | 1 | Timeout occurred while awake: device reset request |
| wakeReq | output | 1 | Timeout occurred while asleep: wake request |
| toFlag | output | 1 | Time-out status bit (0 after a timeout) |
| pdFlag | output | 1 | Power-down status bit (0 after sleep entry) |
| asleep | output | 1 | Sleep-mode flag |

## Verification
The properties rely on the reset being the only other source of change in the status bits. They take the instruction strobes to be single-cycle pulses that arrive only from an executing core. The bench therefore raises each strobe for exactly one clock, and raises both together never. Strobes it issues while asleep are deliberate, to show they are dropped. Tick bursts are long and continuous, so the prescaler phase at every strobe is known and each expected timeout cycle can be computed.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  // Strobes from control to datapath, valid for one clock.
  typedef struct packed {
    logic clrCnt;     // return main counter to zero
    logic clrPre;     // return divider count to zero
    logic tickPre;    // tick routed through the divider
    logic tickDirect; // tick routed straight to the counter
  } wdogStrobe_t;

endpackage

// File: rtl/wdog_dpath.sv
module wdog_dpath #(
  parameter int CNT_W  = 8,
  parameter int RATE_W = 3,
  parameter int PRE_W  = 7
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  wdog_pkg::wdogStrobe_t    strobe,
  input  logic [RATE_W-1:0]        prescRate,
  output logic                     ovfHit
);

  logic [CNT_W-1:0] cnt;
  logic [PRE_W-1:0] preCnt;
  logic [PRE_W-1:0] rateMask;
  logic             preWrap;
  logic             step;

  // Bit i of the mask is set when the divider bit i lies below the rate.
  genvar gi;
  generate
    for (gi = 0; gi < PRE_W; gi++) begin : g_mask
      assign rateMask[gi] = (gi < int'(prescRate));
    end
  endgenerate

  // The divider completes a period when all of its active low bits are ones.
  assign preWrap = &(preCnt | ~rateMask);
  assign step    = strobe.tickDirect | (strobe.tickPre & preWrap);
  assign ovfHit  = step & (&cnt);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt    <= '0;
      preCnt <= '0;
    end else begin
      if (strobe.clrCnt)      cnt <= '0;
      else if (step)          cnt <= cnt + 1'b1;

      if (strobe.clrPre)       preCnt <= '0;
      else if (strobe.tickPre) preCnt <= preCnt + 1'b1;
    end
  end

endmodule

// File: rtl/wdog_ctrl.sv
module wdog_ctrl (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  wdogTick,
  input  logic                  prescToWdog,
  input  logic                  clrWdogCmd,
  input  logic                  sleepCmd,
  input  logic                  ovfHit,
  output wdog_pkg::wdogStrobe_t strobe,
  output logic                  resetReq,
  output logic                  wakeReq,
  output logic                  toFlag,
  output logic                  pdFlag,
  output logic                  asleep
);

  logic doSleep;
  logic doClear;
  logic restart;

  // Strobes count only while the core runs; sleep wins over clear.
  assign doSleep = sleepCmd & ~asleep;
  assign doClear = clrWdogCmd & ~asleep & ~sleepCmd;
  assign restart = doSleep | doClear;

  always_comb begin
    strobe.clrCnt     = restart;
    strobe.clrPre     = restart & prescToWdog;
    strobe.tickPre    = wdogTick & prescToWdog & ~restart;
    strobe.tickDirect = wdogTick & ~prescToWdog & ~restart;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      toFlag   <= 1'b1;
      pdFlag   <= 1'b1;
      asleep   <= 1'b0;
      resetReq <= 1'b0;
      wakeReq  <= 1'b0;
    end else begin
      resetReq <= 1'b0;
      wakeReq  <= 1'b0;
      if (doSleep) begin
        toFlag <= 1'b1;
        pdFlag <= 1'b0;
        asleep <= 1'b1;
      end else if (doClear) begin
        toFlag <= 1'b1;
        pdFlag <= 1'b1;
      end else if (ovfHit) begin
        toFlag <= 1'b0;
        if (asleep) begin
          wakeReq <= 1'b1;
          asleep  <= 1'b0;
        end else begin
          resetReq <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/wdog_sleep_top.sv
module wdog_sleep_top #(
  parameter int CNT_W  = 8,
  parameter int RATE_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wdogTick,
  input  logic              prescToWdog,
  input  logic [RATE_W-1:0] prescRate,
  input  logic              clrWdogCmd,
  input  logic              sleepCmd,
  output logic              timeoutPulse,
  output logic              resetReq,
  output logic              wakeReq,
  output logic              toFlag,
  output logic              pdFlag,
  output logic              asleep
);

  localparam int PRE_W = (1 << RATE_W) - 1;

  wdog_pkg::wdogStrobe_t strobe;
  logic                  ovfHit;

  wdog_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .wdogTick    (wdogTick),
    .prescToWdog (prescToWdog),
    .clrWdogCmd  (clrWdogCmd),
    .sleepCmd    (sleepCmd),
    .ovfHit      (ovfHit),
    .strobe      (strobe),
    .resetReq    (resetReq),
    .wakeReq     (wakeReq),
    .toFlag      (toFlag),
    .pdFlag      (pdFlag),
    .asleep      (asleep)
  );

  wdog_dpath #(
    .CNT_W  (CNT_W),
    .RATE_W (RATE_W),
    .PRE_W  (PRE_W)
  ) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .prescRate (prescRate),
    .ovfHit    (ovfHit)
  );

  assign timeoutPulse = resetReq | wakeReq;

endmodule

// File: rtl/wdog_sleep_chk.sv
module wdog_sleep_chk (
  input logic clk,
  input logic rstN,
  input logic clrWdogCmd,
  input logic sleepCmd,
  input logic timeoutPulse,
  input logic resetReq,
  input logic wakeReq,
  input logic toFlag,
  input logic pdFlag,
  input logic asleep
);

  AST_REQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(resetReq && wakeReq)); // R5

  AST_RESET_ONLY_AWAKE: assert property (@(posedge clk) disable iff (!rstN)
    resetReq |-> !$past(asleep)); // R5

  AST_WAKE_FROM_SLEEP: assert property (@(posedge clk) disable iff (!rstN)
    wakeReq |-> ($past(asleep) && !asleep && !pdFlag)); // R6

  AST_SLEEP_STATUS: assert property (@(posedge clk) disable iff (!rstN)
    (sleepCmd && !asleep) |=> (asleep && toFlag && !pdFlag)); // R4

  AST_CLEAR_STATUS: assert property (@(posedge clk) disable iff (!rstN)
    (clrWdogCmd && !sleepCmd && !asleep) |=> (toFlag && pdFlag)); // R3

  AST_TO_DROP_ON_TIMEOUT: assert property (@(posedge clk) disable iff (!rstN)
    $fell(toFlag) |-> timeoutPulse); // R2

  AST_SLEEP_HOLDS_PD: assert property (@(posedge clk) disable iff (!rstN)
    asleep |-> !pdFlag); // R4

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    timeoutPulse |=> !timeoutPulse); // R2

endmodule

bind wdog_sleep_top wdog_sleep_chk u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .clrWdogCmd   (clrWdogCmd),
  .sleepCmd     (sleepCmd),
  .timeoutPulse (timeoutPulse),
  .resetReq     (resetReq),
  .wakeReq      (wakeReq),
  .toFlag       (toFlag),
  .pdFlag       (pdFlag),
  .asleep       (asleep)
);

// File: tb/wdog_sleep_top_bench.sv
module wdog_sleep_top_bench;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wdogTick = 1'b0;
  logic       prescToWdog = 1'b0;
  logic [2:0] prescRate = 3'd0;
  logic       clrWdogCmd = 1'b0;
  logic       sleepCmd = 1'b0;
  logic       timeoutPulse, resetReq, wakeReq, toFlag, pdFlag, asleep;

  int nChk = 0;
  int nFail = 0;
  int nRst = 0;
  int nWake = 0;
  int nTo = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wdog_sleep_top u_wdog_sleep_top (
    .clk(clk), .rstN(rstN), .wdogTick(wdogTick), .prescToWdog(prescToWdog),
    .prescRate(prescRate), .clrWdogCmd(clrWdogCmd), .sleepCmd(sleepCmd),
    .timeoutPulse(timeoutPulse), .resetReq(resetReq), .wakeReq(wakeReq),
    .toFlag(toFlag), .pdFlag(pdFlag), .asleep(asleep)
  );

  // Pulse tally, sampled away from the active edge.
  always @(negedge clk) begin
    if (resetReq)     nRst++;
    if (wakeReq)      nWake++;
    if (timeoutPulse) nTo++;
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic doTicks(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); wdogTick = 1'b1;
    end
    @(negedge clk); wdogTick = 1'b0;
    @(posedge clk); #1;
  endtask

  task automatic cmd(input bit c, input bit s, input bit t);
    @(negedge clk); clrWdogCmd = c; sleepCmd = s; wdogTick = t;
    @(negedge clk); clrWdogCmd = 1'b0; sleepCmd = 1'b0; wdogTick = 1'b0;
    #1;
  endtask

  // Expect exactly one reset-type timeout after n ticks and none before.
  task automatic expectReset(input string req, input int n);
    int r0;
    int w0;
    r0 = nRst; w0 = nWake;
    doTicks(n - 1);
    chk(req, "no reset before limit", nRst, r0);
    doTicks(1);
    chk(req, "reset at limit", nRst, r0 + 1);
    chk(req, "no wake while awake", nWake, w0);
  endtask

  task automatic t_reset();
    chk("R1", "toFlag in reset", toFlag, 1);
    chk("R1", "pdFlag in reset", pdFlag, 1);
    @(negedge clk); rstN = 1'b1;
    @(posedge clk); #1;
    chk("R1", "toFlag after reset", toFlag, 1);
    chk("R1", "pdFlag after reset", pdFlag, 1);
    chk("R1", "asleep after reset", asleep, 0);
    chk("R1", "no pulses", nRst + nWake + nTo, 0);
  endtask

  task automatic t_directTimeout();
    int t0;
    prescToWdog = 1'b0;
    cmd(1, 0, 0);
    t0 = nTo;
    expectReset("R5", 256);
    chk("R2", "one timeout pulse", nTo, t0 + 1);
    chk("R2", "toFlag cleared", toFlag, 0);
    chk("R5", "pdFlag kept", pdFlag, 1);
  endtask

  task automatic t_clearRestart();
    doTicks(100);
    cmd(1, 0, 1); // tick together with clear: tick dropped
    chk("R3", "toFlag after clear", toFlag, 1);
    chk("R3", "pdFlag after clear", pdFlag, 1);
    expectReset("R3", 256);
  endtask

  task automatic t_sleepWake();
    int r0;
    int w0;
    cmd(0, 1, 0);
    chk("R4", "asleep set", asleep, 1);
    chk("R4", "toFlag set", toFlag, 1);
    chk("R4", "pdFlag cleared", pdFlag, 0);
    r0 = nRst; w0 = nWake;
    doTicks(255);
    chk("R6", "no wake before limit", nWake, w0);
    doTicks(1);
    chk("R6", "wake at limit", nWake, w0 + 1);
    chk("R6", "no reset while asleep", nRst, r0);
    chk("R6", "asleep cleared", asleep, 0);
    chk("R6", "pdFlag stays 0", pdFlag, 0);
    chk("R2", "toFlag cleared on wake", toFlag, 0);
  endtask

  task automatic t_asleepIgnore();
    int w0;
    cmd(0, 1, 0);
    w0 = nWake;
    doTicks(200);
    cmd(1, 0, 0);
    chk("R7", "pdFlag unchanged by clear", pdFlag, 0);
    chk("R7", "toFlag unchanged", toFlag, 1);
    cmd(0, 1, 0);
    doTicks(55);
    chk("R7", "count not restarted", nWake, w0);
    doTicks(1);
    chk("R7", "wake on original schedule", nWake, w0 + 1);
  endtask

  task automatic t_prescaler();
    prescToWdog = 1'b1;
    prescRate = 3'd2;
    cmd(1, 0, 0);
    expectReset("R8", 1024);
    prescRate = 3'd0;
    cmd(1, 0, 0);
    expectReset("R8", 256);
    prescRate = 3'd3;
    cmd(1, 0, 0);
    expectReset("R8", 2048);
  endtask

  task automatic t_presHeld();
    prescToWdog = 1'b1;
    prescRate = 3'd2;
    cmd(1, 0, 0);
    doTicks(2);          // divider holds 2
    prescToWdog = 1'b0;
    cmd(1, 0, 0);        // divider not touched
    prescToWdog = 1'b1;
    expectReset("R9", 1022);
  endtask

  task automatic t_presCleared();
    prescToWdog = 1'b1;
    prescRate = 3'd2;
    cmd(1, 0, 0);
    doTicks(3);          // divider holds 3
    cmd(1, 0, 0);        // divider cleared
    expectReset("R10", 1024);
  endtask

  task automatic t_por();
    prescToWdog = 1'b1;
    prescRate = 3'd1;
    cmd(1, 0, 0);
    doTicks(101);        // counter 50, divider odd
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
    @(posedge clk); #1;
    chk("R11", "toFlag after reset", toFlag, 1);
    chk("R11", "pdFlag after reset", pdFlag, 1);
    expectReset("R11", 512);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL all watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", nChk, nFail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    t_directTimeout();
    t_clearRestart();
    t_sleepWake();
    t_asleepIgnore();
    t_prescaler();
    t_presHeld();
    t_presCleared();
    t_por();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nChk, nFail);
    $finish;
  end

endmodule